// File: doc/BRIEF.md
# Clock Source Switch Controller

This block lets software move the system clock from one oscillator to another and change a power-of-two post-divider, without stopping the system clock and without producing a runt pulse. Software writes a target source code and a divider code through a small write port. The block keeps the system running on the present source until the target reports that it is stable. It then hands the clock over through a break-before-make multiplexer. A hold bit lets software delay the handoff. Writing the present source and divider back into the request abandons a pending switch.

Each oscillator appears only as a clock input and an asynchronous ready input. Ready inputs are resynchronised into the control clock before they are used. Status bits report when the target has become usable and when no request is outstanding. A sticky flag, which an enable bit can route to an interrupt output, records each time a target became usable. The present source and divider are visible on output ports.

Top module: `clk_switch_ctrl`

## Requirements
- R1: After a request naming another source, `cur_src` and the `sys_clk` rate stay on the old source for as long as the requested source's `src_rdy` is low. The handoff completes once that input has been high long enough to pass its synchroniser.
- R2: A request whose source code equals `cur_src` is treated as ready at once, whatever the `src_rdy` of that source. This covers a divider-only change. With the hold bit set, `new_rdy` is high by the third control clock edge after the write.
- R3: When a pending request's target becomes usable, `new_rdy` goes high and `sw_flag` is set in the same cycle.
- R4: `irq` is high exactly when `sw_flag` is 1 and the interrupt enable bit is 1.
- R5: With the hold bit clear, a ready request is committed without further software action. With the hold bit set, `cur_src` and `cur_div` do not change. Clearing the hold bit lets the pending switch complete.
- R6: Writing a request equal to the present source and divider abandons a pending switch. `new_rdy` clears, no handoff takes place, and `sys_clk` keeps its rate.
- R7: `osc_rdy` is 1 when the requested source and divider equal `cur_src` and `cur_div` and no handoff is in flight. Otherwise it is 0.
- R8: `sw_flag` stays set until a control write carries 0 in bit 2. A control write carrying 1 in bit 2 leaves it unchanged.
- R9: At most one source clock is enabled into the multiplexer at any time. `cur_src` changes only after the new source's enable has been confirmed and the old one's removed. No `sys_clk` high pulse is shorter than half a period of the source that produced it.
- R10: `sys_clk` runs at the selected source's rate divided by 2^`cur_div`, where code 0 is divide-by-1. A new divider code takes effect only when the divide counter wraps.
- R11: After reset, `cur_src` equals the `RESET_SRC` parameter (0 by default). `cur_div`, `new_rdy`, `sw_flag` and `irq` are 0, and `osc_rdy` is 1.
- R12: Write encoding. With `wr_sel` = 0 (request), `wr_data[2:0]` is the source code and `wr_data[6:3]` is the divider code. With `wr_sel` = 1 (control), bit 0 is hold, bit 1 is interrupt enable and bit 2 is the flag write-zero-to-clear. Other `wr_sel` values have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Free-running control clock for the register port and state machine |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | NSRC | One clock per oscillator source |
| src_rdy | input | NSRC | Asynchronous stable indication per source |
| wr_en | input | 1 | Write strobe, one control-clock cycle |
| wr_sel | input | 2 | Write target: 0 request, 1 control |
| wr_data | input | DATA_W | Write data |
| sys_clk | output | 1 | Multiplexed and divided system clock |
| cur_src | output | SRC_W | Source presently driving the system clock |
| cur_div | output | DIV_W | Divider code presently applied |
| new_rdy | output | 1 | Pending target is usable |
| osc_rdy | output | 1 | No request outstanding |
| sw_flag | output | 1 | Sticky switch-ready flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every source clock keeps toggling while its enable is being raised or removed, because a break-before-make handoff needs both clocks to retire. They also assume that `wr_en` pulses last a single control cycle and that `src_rdy` changes are slow compared with the synchroniser. The stimulus keeps all oscillator clocks running throughout. It drives writes on the falling control edge for one cycle, and it moves ready inputs only between measurement windows, never while a rate is being counted.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
   localparam logic [1:0] SEL_REQ  = 2'd0;
   localparam logic [1:0] SEL_CTRL = 2'd1;
   localparam int HOLD_BIT = 0;
   localparam int IE_BIT   = 1;
   localparam int FLAG_BIT = 2;
   typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_HAND = 1'b1} sw_state_t;
endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
   parameter int W = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= RST_VAL;
         q    <= RST_VAL;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/clksw_gfmux.sv
`timescale 1ns/1ps
module clksw_gfmux #(
   parameter int NSRC      = 4,
   parameter int SRC_W     = 3,
   parameter int RESET_SRC = 0
) (
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src_clk,
   input  logic [SRC_W-1:0] sel,
   input  logic             ctl_clk,
   output logic [NSRC-1:0]  en_ack,
   output logic             mclk
);
   localparam logic [NSRC-1:0] RST_HOT = NSRC'(1) << RESET_SRC;

   logic [NSRC-1:0] en_g;
   logic [NSRC-1:0] gclk;

   for (genvar i = 0; i < NSRC; i++) begin : g_leg
      localparam logic [SRC_W-1:0] IDX  = SRC_W'(i);
      localparam logic [NSRC-1:0]  SELF = NSRC'(1) << i;
      localparam logic             RST_EN = (i == RESET_SRC);
      logic want, want_s, en_q;

      // enable only once every other leg is confirmed off
      always_comb want = (sel == IDX) && !(|(en_g & ~SELF));

      clksw_sync #(.W(1), .RST_VAL(RST_EN)) u_want_sync (
         .clk(src_clk[i]), .rst_n(rst_n), .d(want), .q(want_s));

      // final stage on the falling edge so the gate moves while the clock is low
      always_ff @(negedge src_clk[i] or negedge rst_n) begin
         if (!rst_n) en_q <= RST_EN;
         else        en_q <= want_s;
      end

      assign en_g[i] = en_q;
      assign gclk[i] = src_clk[i] & en_q;
   end

   assign mclk = |gclk;

   clksw_sync #(.W(NSRC), .RST_VAL(RST_HOT)) u_ack_sync (
      .clk(ctl_clk), .rst_n(rst_n), .d(en_g), .q(en_ack));
endmodule

// File: rtl/clksw_postdiv.sv
`timescale 1ns/1ps
module clksw_postdiv #(
   parameter int DIV_W = 4
) (
   input  logic             mclk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] code_in,
   output logic             sys_clk
);
   localparam int CNT_W = (1 << DIV_W) - 1;

   logic [DIV_W-1:0] code_s1, code_s2, code_s3, code_act;
   logic [CNT_W-1:0] cnt, last;
   logic             gate;

   always_comb last = (CNT_W'(1) << code_act) - CNT_W'(1);

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         code_s1  <= '0;
         code_s2  <= '0;
         code_s3  <= '0;
         code_act <= '0;
         cnt      <= '0;
      end else begin
         code_s1 <= code_in;
         code_s2 <= code_s1;
         code_s3 <= code_s2;
         if (cnt == last) begin
            cnt <= '0;
            // take a new code only at the wrap and only once it has settled
            if (code_s2 == code_s3) code_act <= code_s2;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end

   // pulse-swallowing gate, updated while mclk is low
   always_ff @(negedge mclk or negedge rst_n) begin
      if (!rst_n) gate <= 1'b1;
      else        gate <= (cnt == last);
   end

   assign sys_clk = mclk & gate;

   p_div_boundary_r10: assert property (@(posedge mclk) disable iff (!rst_n)
      (code_act != $past(code_act)) |-> (cnt == '0));
endmodule

// File: rtl/clksw_core.sv
`timescale 1ns/1ps
module clksw_core
   import clksw_pkg::*;
#(
   parameter int NSRC      = 4,
   parameter int SRC_W     = 3,
   parameter int DIV_W     = 4,
   parameter int DATA_W    = 8,
   parameter int RESET_SRC = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            wr_sel,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [(1<<SRC_W)-1:0] rdy_s,
   input  logic [NSRC-1:0]       ack,
   output logic [SRC_W-1:0]      mux_sel,
   output logic [SRC_W-1:0]      cur_src,
   output logic [DIV_W-1:0]      cur_div,
   output logic                  new_rdy,
   output logic                  osc_rdy,
   output logic                  sw_flag,
   output logic                  irq
);
   localparam logic [SRC_W-1:0] RST_SRC = SRC_W'(RESET_SRC);

   sw_state_t        st;
   logic [SRC_W-1:0] req_src;
   logic [DIV_W-1:0] req_div, hs_div;
   logic             hold, ie;
   logic             wr_req, wr_ctl, pending, same, tgt_ok, ack_match, set_ev;
   logic [NSRC-1:0]  sel_hot;
   logic             unused_data;

   assign unused_data = ^wr_data;

   always_comb begin
      wr_req    = wr_en && (wr_sel == SEL_REQ);
      wr_ctl    = wr_en && (wr_sel == SEL_CTRL);
      same      = (req_src == cur_src);
      pending   = !same || (req_div != cur_div);
      tgt_ok    = same || rdy_s[req_src];
      sel_hot   = NSRC'(1) << mux_sel;
      ack_match = (ack == sel_hot);
      set_ev    = (st == ST_IDLE) && pending && tgt_ok && !new_rdy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         req_src <= RST_SRC;
         req_div <= '0;
         hold    <= 1'b0;
         ie      <= 1'b0;
         sw_flag <= 1'b0;
         new_rdy <= 1'b0;
         mux_sel <= RST_SRC;
         hs_div  <= '0;
         cur_src <= RST_SRC;
         cur_div <= '0;
      end else begin
         if (wr_req) begin
            req_src <= wr_data[SRC_W-1:0];
            req_div <= wr_data[SRC_W +: DIV_W];
         end
         if (wr_ctl) begin
            hold <= wr_data[HOLD_BIT];
            ie   <= wr_data[IE_BIT];
         end
         if (set_ev)                              sw_flag <= 1'b1;
         else if (wr_ctl && !wr_data[FLAG_BIT])   sw_flag <= 1'b0;

         unique case (st)
            ST_IDLE: begin
               if (pending && tgt_ok) begin
                  new_rdy <= 1'b1;
                  if (new_rdy && !hold) begin
                     if (same) begin
                        cur_div <= req_div;
                        new_rdy <= 1'b0;
                     end else begin
                        mux_sel <= req_src;
                        hs_div  <= req_div;
                        st      <= ST_HAND;
                     end
                  end
               end else begin
                  new_rdy <= 1'b0;
               end
            end
            ST_HAND: begin
               if (ack_match) begin
                  cur_src <= mux_sel;
                  cur_div <= hs_div;
                  new_rdy <= 1'b0;
                  st      <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign osc_rdy = !pending && (st == ST_IDLE);
   assign irq     = sw_flag & ie;

   p_switch_after_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_src != $past(cur_src)) |-> $past(new_rdy));
   p_ready_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(new_rdy) |-> sw_flag);
   p_hold_freezes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && hold) |=> ($stable(cur_src) && $stable(cur_div)));
   p_abandon_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !pending) |=> !new_rdy);
   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_flag && !(wr_ctl && !wr_data[FLAG_BIT])) |=> sw_flag);
   p_one_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack));
   p_commit_confirmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_src != $past(cur_src)) |-> (ack == (NSRC'(1) << cur_src)));
endmodule

// File: rtl/clk_switch_ctrl.sv
`timescale 1ns/1ps
module clk_switch_ctrl #(
   parameter int NSRC      = 4,
   parameter int SRC_W     = 3,
   parameter int DIV_W     = 4,
   parameter int DATA_W    = 8,
   parameter int RESET_SRC = 0
) (
   input  logic              ctl_clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_clk,
   input  logic [NSRC-1:0]   src_rdy,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              sys_clk,
   output logic [SRC_W-1:0]  cur_src,
   output logic [DIV_W-1:0]  cur_div,
   output logic              new_rdy,
   output logic              osc_rdy,
   output logic              sw_flag,
   output logic              irq
);
   localparam int NCODE = 1 << SRC_W;

   if (NSRC < 2 || NSRC > NCODE) begin : g_bad_nsrc
      $error("NSRC must lie between 2 and 2**SRC_W");
   end
   if (RESET_SRC < 0 || RESET_SRC >= NSRC) begin : g_bad_rst
      $error("RESET_SRC must name an existing source");
   end
   if (SRC_W + DIV_W > DATA_W || DATA_W < 3 || DIV_W < 1) begin : g_bad_fields
      $error("request fields and control bits must fit wr_data");
   end

   logic [NSRC-1:0]  rdy_s, ack;
   logic [NCODE-1:0] rdy_pad;
   logic [SRC_W-1:0] mux_sel;
   logic             mclk;

   clksw_sync #(.W(NSRC), .RST_VAL('0)) u_rdy_sync (
      .clk(ctl_clk), .rst_n(rst_n), .d(src_rdy), .q(rdy_s));

   always_comb begin
      rdy_pad = '0;
      rdy_pad[NSRC-1:0] = rdy_s;
   end

   clksw_core #(.NSRC(NSRC), .SRC_W(SRC_W), .DIV_W(DIV_W), .DATA_W(DATA_W),
                .RESET_SRC(RESET_SRC)) u_core (
      .clk(ctl_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rdy_s(rdy_pad), .ack(ack), .mux_sel(mux_sel),
      .cur_src(cur_src), .cur_div(cur_div), .new_rdy(new_rdy),
      .osc_rdy(osc_rdy), .sw_flag(sw_flag), .irq(irq));

   clksw_gfmux #(.NSRC(NSRC), .SRC_W(SRC_W), .RESET_SRC(RESET_SRC)) u_mux (
      .rst_n(rst_n), .src_clk(src_clk), .sel(mux_sel), .ctl_clk(ctl_clk),
      .en_ack(ack), .mclk(mclk));

   clksw_postdiv #(.DIV_W(DIV_W)) u_div (
      .mclk(mclk), .rst_n(rst_n), .code_in(cur_div), .sys_clk(sys_clk));
endmodule

// File: tb/clk_switch_ctrl_test.sv
`timescale 1ns/1ps
module clk_switch_ctrl_test;
   logic       ctl_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
   logic [3:0] src_rdy = 4'hF;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       sys_clk, new_rdy, osc_rdy, sw_flag, irq;
   logic [2:0] cur_src;
   logic [3:0] cur_div;

   int total = 0;
   int fails = 0;
   int sys_edges = 0;
   realtime t_rise = 0.0;
   realtime min_high = 1.0e9;

   always #4 ctl_clk = ~ctl_clk;   // 125 MHz
   always #5 c0 = ~c0;             // 10 ns
   always #7 c1 = ~c1;             // 14 ns
   always #3 c2 = ~c2;             // 6 ns
   always #10 c3 = ~c3;            // 20 ns

   clk_switch_ctrl uut (
      .ctl_clk(ctl_clk), .rst_n(rst_n), .src_clk({c3, c2, c1, c0}),
      .src_rdy(src_rdy), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .sys_clk(sys_clk), .cur_src(cur_src), .cur_div(cur_div),
      .new_rdy(new_rdy), .osc_rdy(osc_rdy), .sw_flag(sw_flag), .irq(irq));

   always @(posedge sys_clk) begin
      sys_edges++;
      t_rise = $realtime;
   end
   always @(negedge sys_clk) begin
      if (t_rise > 0.0 && ($realtime - t_rise) < min_high) min_high = $realtime - t_rise;
   end

   // columns: source code, divider code
   localparam logic [6:0] VEC [0:4] = '{
      {3'd1, 4'd0}, {3'd2, 4'd1}, {3'd3, 4'd2}, {3'd0, 4'd3}, {3'd2, 4'd0}};

   function automatic int period_ns(input int s);
      case (s)
         0: return 10;
         1: return 14;
         2: return 6;
         default: return 20;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] data);
      @(negedge ctl_clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge ctl_clk);
      wr_en = 1'b0;
   endtask

   task automatic req(input int s, input int d);
      wr(2'd0, {1'b0, 4'(d), 3'(s)});
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge ctl_clk);
   endtask

   task automatic rate(input string tag, input int s, input int d);
      int start, n, exp;
      start = sys_edges;
      #4000;
      n = sys_edges - start;
      exp = 4000 / (period_ns(s) << d);
      check(n >= exp - 3 && n <= exp + 3, tag, "sys_clk edges in 4us", n, exp);
   endtask

   initial begin
      #2000000;
      fails++;
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #100;
      @(negedge ctl_clk);
      rst_n = 1'b1;
      cyc(2);
      // R11 reset state
      check(cur_src == 3'd0, "R11", "cur_src", cur_src, 0);
      check(cur_div == 4'd0, "R11", "cur_div", cur_div, 0);
      check(!new_rdy && !sw_flag && !irq, "R11", "new_rdy|flag|irq",
            {new_rdy, sw_flag, irq}, 0);
      check(osc_rdy, "R11", "osc_rdy", osc_rdy, 1);
      cyc(20);
      rate("R10", 0, 0);

      // table walk: R5 R7 R10 R12 completion with hold clear
      for (int k = 0; k < 5; k++) begin
         int s, d;
         s = int'(VEC[k][6:4]);
         d = int'(VEC[k][3:0]);
         req(s, d);
         cyc(80);
         check(cur_src == 3'(s), "R5", "cur_src after request", cur_src, s);
         check(cur_div == 4'(d), "R12", "cur_div after request", cur_div, d);
         check(osc_rdy && !new_rdy, "R7", "osc_rdy,!new_rdy", {osc_rdy, new_rdy}, 2);
         rate("R10", s, d);
      end

      // R8 and R4: flag stickiness and interrupt gating
      check(sw_flag, "R3", "flag after switches", sw_flag, 1);
      wr(2'd1, 8'b100);
      cyc(2);
      check(sw_flag, "R8", "flag after write of 1", sw_flag, 1);
      check(!irq, "R4", "irq with enable 0", irq, 0);
      wr(2'd1, 8'b110);
      cyc(2);
      check(irq, "R4", "irq with enable 1", irq, 1);
      wr(2'd3, 8'b000);
      cyc(2);
      check(sw_flag && irq, "R12", "unused select ignored", {sw_flag, irq}, 3);
      wr(2'd1, 8'b000);
      cyc(2);
      check(!sw_flag && !irq, "R8", "flag cleared", {sw_flag, irq}, 0);

      // R1: wait for a source that is not ready
      src_rdy[3] = 1'b0;
      req(3, 0);
      cyc(40);
      check(cur_src == 3'd2, "R1", "cur_src while target not ready", cur_src, 2);
      check(!new_rdy && !osc_rdy, "R7", "new_rdy,osc_rdy pending", {new_rdy, osc_rdy}, 0);
      rate("R1", 2, 0);
      src_rdy[3] = 1'b1;
      cyc(80);
      check(cur_src == 3'd3, "R1", "cur_src after ready", cur_src, 3);
      check(sw_flag, "R3", "flag after ready", sw_flag, 1);

      // R5: hold suspends, release completes
      wr(2'd1, 8'b001);
      req(1, 1);
      cyc(30);
      check(new_rdy && sw_flag, "R3", "new_rdy,flag under hold", {new_rdy, sw_flag}, 3);
      check(cur_src == 3'd3, "R5", "cur_src under hold", cur_src, 3);
      wr(2'd1, 8'b100);
      cyc(80);
      check(cur_src == 3'd1 && cur_div == 4'd1, "R5", "src,div after release",
            {cur_src, cur_div}, {3'd1, 4'd1});
      check(!new_rdy, "R5", "new_rdy after commit", new_rdy, 0);

      // R6: abandon a held switch
      wr(2'd1, 8'b101);
      req(0, 2);
      cyc(30);
      check(new_rdy, "R6", "new_rdy before abandon", new_rdy, 1);
      req(1, 1);
      cyc(10);
      check(!new_rdy && osc_rdy, "R6", "new_rdy,osc_rdy after abandon",
            {new_rdy, osc_rdy}, 1);
      wr(2'd1, 8'b100);
      cyc(40);
      check(cur_src == 3'd1 && cur_div == 4'd1, "R6", "no handoff",
            {cur_src, cur_div}, {3'd1, 4'd1});
      rate("R6", 1, 1);

      // R2: divider-only change ready at once even with ready input low
      src_rdy[1] = 1'b0;
      wr(2'd1, 8'b001);
      req(1, 2);
      cyc(2);
      check(new_rdy, "R2", "new_rdy for same source", new_rdy, 1);
      check(sw_flag, "R3", "flag for same source", sw_flag, 1);
      wr(2'd1, 8'b100);
      cyc(10);
      check(cur_div == 4'd2 && cur_src == 3'd1, "R2", "div-only commit",
            {cur_src, cur_div}, {3'd1, 4'd2});
      cyc(20);
      rate("R10", 1, 2);
      src_rdy[1] = 1'b1;

      // R9: no shortened high pulse across all handoffs
      check(min_high > 2.9, "R9", "min high ps", int'(min_high * 1000.0), 3000);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule